// File: doc/BRIEF.md
# PAM4/NRZ Transmit Encoder and Serializer

This block is the digital transmit path of one serial lane. It accepts a parallel word over a valid/ready handshake. It then emits the word one unit per clock: a single bit in NRZ mode, or a 2-bit symbol in PAM4 mode. The least significant end of the word always goes first. In PAM4 mode each adjacent bit pair can be Gray-mapped before it leaves. In either mode a switchable 1/(1+D) precoder can be placed in the path, and its state runs across word boundaries.

The word length is picked per word from five factors. The mode, the Gray enable and the factor are captured when a word is accepted, so a change to them takes effect only at the next word. The precoder enable is applied symbol by symbol. A new word is taken while the last unit of the current word is leaving, so a steady supply of words gives an unbroken output stream.

Top module: `txl_ser_top`

## Requirements
- R1: While reset is asserted, and after it is released with no word accepted, ready_o is 1, ser_vld_o is 0 and ser_o is 0.
- R2: fsel_i selects the word length at acceptance: 0 gives 16 bits, 1 gives 20, 2 gives 32, 3 gives 40, and 4 to 7 give 64. An NRZ word produces that many output cycles, and a PAM4 word produces half that many.
- R3: Units leave LSB first. In NRZ mode, output k is {0, data[k]}, so ser_o[1] is always 0. In PAM4 mode, symbol k is {data[2k+1], data[2k]} before encoding.
- R4: With PAM4 mode and Gray enable both captured high, each symbol is mapped 00 to 00, 01 to 01, 10 to 11 and 11 to 10. Otherwise the symbol passes through unchanged.
- R5: In NRZ mode with pre_en_i high, the output bit is y = x XOR y_prev.
- R6: In PAM4 mode with pre_en_i high, the output symbol is y = (g - y_prev) mod 4, where g is the symbol after the R4 mapping.
- R7: The precoder state is 0 after reset and is forced to 0 in every cycle with pre_en_i low. While pre_en_i stays high, the state carries from the last unit of one word to the first unit of the next.
- R8: ready_o is 1 exactly when the remaining unit count is 0 or 1. The first unit of an accepted word is on ser_o in the cycle after acceptance. A word accepted on the last unit follows with no idle cycle.
- R9: pam4_i, gray_en_i and fsel_i are sampled only at acceptance. Changing them mid-word has no effect, and data bits above the selected length have no effect.
- R10: pre_en_i is applied to each unit at the clock edge that emits it, so toggling it mid-word changes precoding from that unit on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock, one unit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 64 | Parallel word, bit 0 leaves first |
| valid_i | input | 1 | Word on data_i is valid |
| ready_o | output | 1 | Block takes a word this cycle if valid_i |
| pam4_i | input | 1 | 1 for PAM4 symbols, 0 for NRZ bits |
| gray_en_i | input | 1 | Gray mapping enable (PAM4 only) |
| pre_en_i | input | 1 | 1/(1+D) precoder enable |
| fsel_i | input | 3 | Word length select |
| ser_o | output | 2 | Output unit; NRZ uses bit 0 |
| ser_vld_o | output | 1 | ser_o carries a unit |

## Verification
Two things can happen at the same clock edge. The last unit of one word can be emitted and precoded while the next word is loaded with different mode, Gray and length settings. Also, a rise of pre_en_i can coincide with that word boundary, so that the state reset and the carry meet. The stimulus keeps valid_i high most of the time while mode, length and Gray enable change on every cycle and pre_en_i flips now and then, which makes both collisions frequent. Each emitted unit is compared with a bench model that takes the settings latched at acceptance and applies pre_en_i as it stood at the emitting edge.

// File: rtl/txl_pkg.sv
package txl_pkg;
  localparam int unsigned FSEL_W = 3;

  // word length in bits for a length select code
  function automatic int unsigned fsel_bits(input logic [FSEL_W-1:0] f);
    case (f)
      3'd0:    return 16;
      3'd1:    return 20;
      3'd2:    return 32;
      3'd3:    return 40;
      default: return 64;
    endcase
  endfunction

  function automatic int unsigned fsel_units(input logic [FSEL_W-1:0] f, input logic pam4);
    return pam4 ? (fsel_bits(f) >> 1) : fsel_bits(f);
  endfunction
endpackage

// File: rtl/txl_shifter.sv
module txl_shifter
  import txl_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              pam4_i,
  input  logic              gray_i,
  input  logic [FSEL_W-1:0] fsel_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic [1:0]        sym_o,
  output logic              sym_pam4_o,
  output logic              sym_gray_o
);
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pam4_q, gray_q;
  logic              load;

  assign busy_o     = (cnt_q != '0);
  assign ready_o    = (cnt_q <= CNT_W'(1));
  assign load       = valid_i && ready_o;
  assign sym_o      = pam4_q ? shreg_q[1:0] : {1'b0, shreg_q[0]};
  assign sym_pam4_o = pam4_q;
  assign sym_gray_o = gray_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      pam4_q  <= 1'b0;
      gray_q  <= 1'b0;
    end else begin
      if (busy_o) begin
        shreg_q <= pam4_q ? (shreg_q >> 2) : (shreg_q >> 1);
        cnt_q   <= cnt_q - CNT_W'(1);
      end
      if (load) begin
        shreg_q <= data_i;
        cnt_q   <= CNT_W'(fsel_units(fsel_i, pam4_i));
        pam4_q  <= pam4_i;
        gray_q  <= gray_i;
      end
    end
  end

  // R8
  gapless_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > CNT_W'(1)) |=> (cnt_q != '0));

  // R2
  load_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (cnt_q == CNT_W'(fsel_units($past(fsel_i), $past(pam4_i)))));
endmodule

// File: rtl/txl_gray_map.sv
module txl_gray_map (
  input  logic       en_i,
  input  logic [1:0] sym_i,
  output logic [1:0] sym_o
);
  assign sym_o = en_i ? {sym_i[1], sym_i[1] ^ sym_i[0]} : sym_i;
endmodule

// File: rtl/txl_precoder.sv
module txl_precoder (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  input  logic       pam4_i,
  input  logic       pre_en_i,
  input  logic [1:0] sym_i,
  output logic [1:0] ser_o,
  output logic       ser_vld_o
);
  logic [1:0] st_q, y, out;

  always_comb begin
    if (pam4_i) y = sym_i - st_q;
    else        y = {1'b0, sym_i[0] ^ st_q[0]};
    out = pre_en_i ? y : sym_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= '0;
      ser_o     <= '0;
      ser_vld_o <= 1'b0;
    end else begin
      ser_vld_o <= fire_i;
      ser_o     <= fire_i ? out : 2'b00;
      if (!pre_en_i)   st_q <= '0;
      else if (fire_i) st_q <= y;
    end
  end

  // R7
  pre_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_en_i |=> (st_q == 2'b00));

  // R5
  nrz_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && pre_en_i && !pam4_i) |=> (ser_o == {1'b0, st_q[0]}));
endmodule

// File: rtl/txl_ser_top.sv
module txl_ser_top
  import txl_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              pam4_i,
  input  logic              gray_en_i,
  input  logic              pre_en_i,
  input  logic [FSEL_W-1:0] fsel_i,
  output logic [1:0]        ser_o,
  output logic              ser_vld_o
);
  logic       busy, sym_pam4, sym_gray;
  logic [1:0] raw_sym, gray_sym;

  txl_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .data_i, .valid_i,
    .pam4_i, .gray_i(gray_en_i), .fsel_i,
    .ready_o, .busy_o(busy), .sym_o(raw_sym),
    .sym_pam4_o(sym_pam4), .sym_gray_o(sym_gray)
  );

  txl_gray_map u_gray (
    .en_i(sym_pam4 && sym_gray), .sym_i(raw_sym), .sym_o(gray_sym)
  );

  txl_precoder u_pre (
    .clk_i, .rst_ni, .fire_i(busy), .pam4_i(sym_pam4), .pre_en_i,
    .sym_i(gray_sym), .ser_o, .ser_vld_o
  );

  // R8
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ser_vld_o);

  // R3
  nrz_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !sym_pam4) |=> (ser_o[1] == 1'b0));
endmodule

// File: tb/txl_ser_top_tb_top.sv
module txl_ser_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] data_i = '0;
  logic        valid_i = 1'b0;
  logic        pam4_i = 1'b0, gray_en_i = 1'b0, pre_en_i = 1'b0;
  logic [2:0]  fsel_i = '0;
  logic        ready_o, ser_vld_o;
  logic [1:0]  ser_o;

  int unsigned checks = 0, errors = 0, vld_cnt = 0;
  logic [3:0]  q[$];   // {pam4, gray, sym}
  logic [1:0]  m_st = '0;
  bit          last_acc;

  always #10 clk_i = ~clk_i;

  txl_ser_top dut_i (.*);

  function automatic int unsigned len_bits(input logic [2:0] f);
    if (f == 3'd0) return 16;
    if (f == 3'd1) return 20;
    if (f == 3'd2) return 32;
    if (f == 3'd3) return 40;
    return 64;
  endfunction

  function automatic logic [1:0] gray_lut(input logic [1:0] s);
    case (s)
      2'b10:   return 2'b11;
      2'b11:   return 2'b10;
      default: return s;
    endcase
  endfunction

  task automatic fail(input string r, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
  endtask

  task automatic step();
    bit acc; bit ev; logic [1:0] es; logic [3:0] e; logic [1:0] g;
    logic [63:0] d; logic [2:0] f; logic p, gr; string tag;
    checks++;
    if (ready_o !== (q.size() <= 1)) fail("R8 ready", 64'(ready_o), 64'(q.size() <= 1));
    acc = valid_i && ready_o;
    d = data_i; f = fsel_i; p = pam4_i; gr = gray_en_i;
    @(posedge clk_i);
    ev = 1'b0; es = 2'b00; tag = "R3";
    if (q.size() > 0) begin
      e  = q.pop_front();
      ev = 1'b1;
      g  = (e[3] && e[2]) ? gray_lut(e[1:0]) : e[1:0];
      if (e[3] && e[2]) tag = "R4";
      if (pre_en_i) begin
        tag = e[3] ? "R6" : "R5";
        es  = e[3] ? (g - m_st) : {1'b0, g[0] ^ m_st[0]};
      end else es = g;
    end
    if (!pre_en_i) m_st = 2'b00;
    else if (ev)   m_st = es;
    if (acc) begin
      if (p) for (int k = 0; k < int'(len_bits(f) / 2); k++) q.push_back({1'b1, gr, d[2*k+1], d[2*k]});
      else   for (int k = 0; k < int'(len_bits(f)); k++)     q.push_back({1'b0, gr, 1'b0, d[k]});
    end
    last_acc = acc;
    @(negedge clk_i);
    checks++;
    if (ser_vld_o !== ev) fail("R8 vld", 64'(ser_vld_o), 64'(ev));
    checks++;
    if (ser_o !== es) fail(tag, 64'(ser_o), 64'(es));
    if (ser_vld_o) vld_cnt++;
  endtask

  task automatic send(input logic [63:0] d, input logic p, input logic gr, input logic [2:0] f);
    data_i = d; pam4_i = p; gray_en_i = gr; fsel_i = f; valid_i = 1'b1;
    do step(); while (!last_acc);
    valid_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) step();
  endtask

  initial begin
    void'($urandom(32'd4711));
    #5;
    // R1
    checks++;
    if (ready_o !== 1'b1 || ser_vld_o !== 1'b0 || ser_o !== 2'b00)
      fail("R1 reset", {ready_o, ser_vld_o, ser_o}, 64'b1000);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (ready_o !== 1'b1 || ser_vld_o !== 1'b0 || ser_o !== 2'b00)
      fail("R1 idle", {ready_o, ser_vld_o, ser_o}, 64'b1000);

    // R2 length sweep; upper bits random (R9)
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 2; p++) begin
        vld_cnt = 0;
        send({$urandom, $urandom}, p[0], 1'b1, f[2:0]);
        drain();
        checks++;
        if (vld_cnt != (p != 0 ? len_bits(f[2:0]) / 2 : len_bits(f[2:0])))
          fail("R2 count", 64'(vld_cnt), 64'(p != 0 ? len_bits(f[2:0]) / 2 : len_bits(f[2:0])));
      end

    // R9: settings change mid-word, word keeps its captured length
    vld_cnt = 0;
    send(64'h0123_4567_89ab_cdef, 1'b1, 1'b1, 3'd0);
    pam4_i = 1'b0; gray_en_i = 1'b0; fsel_i = 3'd4;
    drain();
    checks++;
    if (vld_cnt != 8) fail("R9 count", 64'(vld_cnt), 64'd8);

    // R7 carry across back-to-back PAM4 words, R10 mid-word toggle
    pre_en_i = 1'b1;
    send(64'hffff_0000_a5a5_3c3c, 1'b1, 1'b1, 3'd0);
    send(64'h1234_5678_9abc_def0, 1'b1, 1'b1, 3'd1);
    send(64'h0000_0000_0000_ffff, 1'b0, 1'b0, 3'd0);
    repeat (5) step();
    pre_en_i = 1'b0; step();
    pre_en_i = 1'b1; drain();

    // Random mix, heavy word-boundary traffic
    for (int n = 0; n < 6000; n++) begin
      valid_i   = ($urandom % 8) != 0;
      data_i    = {$urandom, $urandom};
      pam4_i    = $urandom % 2;
      gray_en_i = $urandom % 2;
      fsel_i    = 3'($urandom % 8);
      if (($urandom % 16) == 0) pre_en_i = ~pre_en_i;
      step();
    end
    valid_i = 1'b0;
    drain();
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule